// File: doc/BRIEF.md
# Key-Restarted Watchdog with Early-Warning Timer

This block is a small watchdog peripheral with an 8-bit register bus. It holds two down-counters that are clocked by a slow reference tick. The first is the watchdog counter. When it runs out, the block sends a one-cycle reset request to the system. The second is an early-warning timer. It raises a sticky interrupt each time it runs out, so software gets notice before the watchdog fires. A shared prescaler turns the reference tick into one of three rates. Either counter can take its tick from the prescaler.

Software sets the prescaler and both reload counts, then arms the watchdog with the configuration register. The watchdog can only be restarted by writing a fixed key byte. Lock bits freeze the count registers, the prescaler register and the configuration register itself. This keeps a runaway program from quietly stretching the timeout. The warning timer reloads itself after each expiry and can also be reloaded on demand through the control register.

Top module: `wdk_top`

## Requirements
- R1: After reset, every register reads 0x00, `warn_irq` is low and `wdog_rst_req` is low. Registers: configuration 0x01, prescaler 0x02, warning count high/low 0x03/0x04, control 0x05, watchdog count low 0x06, key 0x07, watchdog count high 0x09. The count addresses read back the live counters; unmapped addresses read 0x00.
- R2: The prescaler register selects the prescaled tick. Code 0 gives every reference tick. Code 1 gives one in 32. Code 2 (and 3) gives one in 1024. The division runs on a free-running count of reference ticks.
- R3: Configuration bit4 = 1 clocks the watchdog counter from the prescaled tick. Bit4 = 0 clocks it from the raw reference tick.
- R4: A configuration write that sets bit3 while bit3 is clear arms the watchdog. The counter loads from {0x09, 0x06} and then counts down once per selected tick. While bit3 is clear the counter holds its value.
- R5: When the watchdog counter steps from 1 to 0, `wdog_rst_req` is high for exactly the following clock cycle. The counter then stays at 0 until it is reloaded.
- R6: Writing 0x5C to 0x07 while configuration bit5 is 1 reloads the watchdog counter from its programmed count. Any other key value, or any write while bit5 is 0, leaves the countdown unchanged.
- R7: Writes are ignored while their lock bit is set. Configuration bit3 locks 0x06/0x09, bit2 locks 0x03/0x04, and bit1 locks 0x02.
- R8: Once configuration bit0 is set, writes to the configuration register are ignored until reset.
- R9: Control bit5 (stop) halts the watchdog counter only while control bit4 (stop mode) is also 1. Bit5 alone has no effect.
- R10: While the watchdog is armed, the warning counter counts down once per prescaled tick. It loads from {0x03, 0x04} when the watchdog is armed. When it steps from 1 it reloads and sets the status flag (control bit1), which drives `warn_irq`.
- R11: The warning status stays set until a control write with bit1 = 1 clears it. A control write with bit1 = 0 leaves it set.
- R12: A control write with bit0 = 1 reloads the warning counter from its count registers. Control bit0 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_tick | input | 1 | One-cycle pulse per reference-clock period |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from `bus_addr` |
| warn_irq | output | 1 | Sticky early-warning interrupt |
| wdog_rst_req | output | 1 | One-cycle watchdog reset request |

## Verification
The assertions assume that a write is a single-cycle `bus_wr` pulse with stable address and data. They also assume that the only things able to move the watchdog counter are the arm write and a matching key write. Both of those are recognised from the bus ports, so the hold and stop properties exclude exactly those two cases. The stimulus drives writes one at a time, away from the clock edge, and holds `ref_tick` high. This makes every tick rate an exact cycle count. Most directed checks read the live counter in the cycle right after a write, which makes each expected value exact.

// File: rtl/wdk_pkg.sv
package wdk_pkg;
   localparam logic [7:0] OFF_CFG  = 8'h01;
   localparam logic [7:0] OFF_PSC  = 8'h02;
   localparam logic [7:0] OFF_WHI  = 8'h03;
   localparam logic [7:0] OFF_WLO  = 8'h04;
   localparam logic [7:0] OFF_CTRL = 8'h05;
   localparam logic [7:0] OFF_DLO  = 8'h06;
   localparam logic [7:0] OFF_KEY  = 8'h07;
   localparam logic [7:0] OFF_DHI  = 8'h09;

   localparam logic [7:0] KICK_KEY = 8'h5C;

   localparam int CFG_KEY_EN = 5;
   localparam int CFG_SRC    = 4;
   localparam int CFG_DLOCK  = 3;
   localparam int CFG_WLOCK  = 2;
   localparam int CFG_PLOCK  = 1;
   localparam int CFG_CLOCK  = 0;

   localparam int CTRL_STOP  = 5;
   localparam int CTRL_MODE  = 4;
   localparam int CTRL_STAT  = 1;
   localparam int CTRL_WRST  = 0;

   typedef enum logic [1:0] {
      PSC_FAST = 2'd0,
      PSC_MID  = 2'd1,
      PSC_SLOW = 2'd2,
      PSC_RSVD = 2'd3
   } psc_sel_e;
endpackage

// File: rtl/wdk_prescaler.sv
module wdk_prescaler
   import wdk_pkg::*;
#(
   parameter int MID_DIV  = 32,
   parameter int SLOW_DIV = 1024
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     ref_tick,
   input  psc_sel_e sel,
   output logic     tick_o
);
   localparam int MID_W  = $clog2(MID_DIV);
   localparam int SLOW_W = $clog2(SLOW_DIV);

   generate
      if ((1 << MID_W) != MID_DIV || (1 << SLOW_W) != SLOW_DIV) begin : g_bad_pow2
         $error("wdk_prescaler: dividers must be powers of two");
      end
      if (MID_DIV < 2 || MID_DIV >= SLOW_DIV) begin : g_bad_order
         $error("wdk_prescaler: need 2 <= MID_DIV < SLOW_DIV");
      end
   endgenerate

   logic [SLOW_W-1:0] div_q;
   logic              wrap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        div_q <= '0;
      else if (ref_tick) div_q <= div_q + 1'b1;
   end

   always_comb begin
      case (sel)
         PSC_FAST: wrap = 1'b1;
         PSC_MID:  wrap = &div_q[MID_W-1:0];
         default:  wrap = &div_q;
      endcase
   end

   assign tick_o = ref_tick && wrap;
endmodule

// File: rtl/wdk_downcnt.sv
module wdk_downcnt #(
   parameter int CNT_W       = 16,
   parameter bit AUTO_RELOAD = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             enable,
   input  logic             load,
   input  logic [CNT_W-1:0] reload_val,
   output logic [CNT_W-1:0] count,
   output logic             expire_o
);
   logic [CNT_W-1:0] wrap_val;

   generate
      if (AUTO_RELOAD) begin : g_reload
         assign wrap_val = reload_val;
      end else begin : g_hold
         assign wrap_val = '0;
      end
   endgenerate

   logic step;
   assign step     = enable && tick && (count != '0);
   assign expire_o = step && !load && (count == CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    count <= '0;
      else if (load) count <= reload_val;
      else if (step) count <= (count == CNT_W'(1)) ? wrap_val : count - 1'b1;
   end
endmodule

// File: rtl/wdk_top.sv
module wdk_top
   import wdk_pkg::*;
#(
   parameter int ADDR_W   = 4,
   parameter int CNT_W    = 16,
   parameter int MID_DIV  = 32,
   parameter int SLOW_DIV = 1024
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ref_tick,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   output logic              warn_irq,
   output logic              wdog_rst_req
);
   localparam int PAD_W = 16 - CNT_W;

   generate
      if (ADDR_W < 4 || ADDR_W > 8) begin : g_bad_addr
         $error("wdk_top: ADDR_W must be 4..8");
      end
      if (CNT_W < 2 || CNT_W > 16) begin : g_bad_cnt
         $error("wdk_top: CNT_W must be 2..16");
      end
   endgenerate

   logic [5:0] cfg_q;
   psc_sel_e   psc_q;
   logic [7:0] whi_q, wlo_q, dhi_q, dlo_q;
   logic       stop_q, mode_q, stat_q, rst_req_q;

   function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [7:0] off);
      return a == off[ADDR_W-1:0];
   endfunction

   logic wr_cfg, wr_psc, wr_whi, wr_wlo, wr_ctrl, wr_dlo, wr_dhi, wr_key;
   assign wr_cfg  = bus_wr && hit(bus_addr, OFF_CFG)  && !cfg_q[CFG_CLOCK];
   assign wr_psc  = bus_wr && hit(bus_addr, OFF_PSC)  && !cfg_q[CFG_PLOCK];
   assign wr_whi  = bus_wr && hit(bus_addr, OFF_WHI)  && !cfg_q[CFG_WLOCK];
   assign wr_wlo  = bus_wr && hit(bus_addr, OFF_WLO)  && !cfg_q[CFG_WLOCK];
   assign wr_dhi  = bus_wr && hit(bus_addr, OFF_DHI)  && !cfg_q[CFG_DLOCK];
   assign wr_dlo  = bus_wr && hit(bus_addr, OFF_DLO)  && !cfg_q[CFG_DLOCK];
   assign wr_ctrl = bus_wr && hit(bus_addr, OFF_CTRL);
   assign wr_key  = bus_wr && hit(bus_addr, OFF_KEY);

   logic running, arm_evt, kick_evt, warn_rst_evt, dog_halt;
   assign running      = cfg_q[CFG_DLOCK];
   assign arm_evt      = wr_cfg && bus_wdata[CFG_DLOCK] && !running;
   assign kick_evt     = wr_key && (bus_wdata == KICK_KEY) && cfg_q[CFG_KEY_EN];
   assign warn_rst_evt = wr_ctrl && bus_wdata[CTRL_WRST];
   assign dog_halt     = stop_q && mode_q;

   // register file
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q  <= '0;
         psc_q  <= PSC_FAST;
         whi_q  <= '0;
         wlo_q  <= '0;
         dhi_q  <= '0;
         dlo_q  <= '0;
         stop_q <= 1'b0;
         mode_q <= 1'b0;
      end else begin
         if (wr_cfg) cfg_q <= bus_wdata[5:0];
         if (wr_psc) psc_q <= psc_sel_e'(bus_wdata[1:0]);
         if (wr_whi) whi_q <= bus_wdata;
         if (wr_wlo) wlo_q <= bus_wdata;
         if (wr_dhi) dhi_q <= bus_wdata;
         if (wr_dlo) dlo_q <= bus_wdata;
         if (wr_ctrl) begin
            stop_q <= bus_wdata[CTRL_STOP];
            mode_q <= bus_wdata[CTRL_MODE];
         end
      end
   end

   // tick generation
   logic psc_tick, dog_tick;
   wdk_prescaler #(.MID_DIV(MID_DIV), .SLOW_DIV(SLOW_DIV)) u_psc (
      .clk      (clk),
      .rst_n    (rst_n),
      .ref_tick (ref_tick),
      .sel      (psc_q),
      .tick_o   (psc_tick)
   );
   assign dog_tick = cfg_q[CFG_SRC] ? psc_tick : ref_tick;

   // watchdog counter
   logic [15:0]      dog_reload16, warn_reload16;
   logic [CNT_W-1:0] dog_cnt, warn_cnt;
   logic             dog_expire, warn_expire;
   assign dog_reload16  = {dhi_q, dlo_q};
   assign warn_reload16 = {whi_q, wlo_q};

   wdk_downcnt #(.CNT_W(CNT_W), .AUTO_RELOAD(1'b0)) u_dog (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (dog_tick),
      .enable     (running && !dog_halt),
      .load       (arm_evt || kick_evt),
      .reload_val (dog_reload16[CNT_W-1:0]),
      .count      (dog_cnt),
      .expire_o   (dog_expire)
   );

   wdk_downcnt #(.CNT_W(CNT_W), .AUTO_RELOAD(1'b1)) u_warn (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (psc_tick),
      .enable     (running),
      .load       (arm_evt || warn_rst_evt),
      .reload_val (warn_reload16[CNT_W-1:0]),
      .count      (warn_cnt),
      .expire_o   (warn_expire)
   );

   // status and reset request
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_q    <= 1'b0;
         rst_req_q <= 1'b0;
      end else begin
         rst_req_q <= dog_expire;
         if (warn_expire)                          stat_q <= 1'b1;
         else if (wr_ctrl && bus_wdata[CTRL_STAT]) stat_q <= 1'b0;
      end
   end

   assign warn_irq     = stat_q;
   assign wdog_rst_req = rst_req_q;

   // read mux
   logic [15:0] dog_live, warn_live;
   generate
      if (PAD_W > 0) begin : g_pad
         assign dog_live  = {{PAD_W{1'b0}}, dog_cnt};
         assign warn_live = {{PAD_W{1'b0}}, warn_cnt};
      end else begin : g_full
         assign dog_live  = dog_cnt;
         assign warn_live = warn_cnt;
      end
   endgenerate

   always_comb begin
      bus_rdata = 8'h00;
      if (hit(bus_addr, OFF_CFG))  bus_rdata = {2'b00, cfg_q};
      if (hit(bus_addr, OFF_PSC))  bus_rdata = {6'b0, psc_q};
      if (hit(bus_addr, OFF_WHI))  bus_rdata = warn_live[15:8];
      if (hit(bus_addr, OFF_WLO))  bus_rdata = warn_live[7:0];
      if (hit(bus_addr, OFF_CTRL)) bus_rdata = {2'b00, stop_q, mode_q, 2'b00, stat_q, 1'b0};
      if (hit(bus_addr, OFF_DLO))  bus_rdata = dog_live[7:0];
      if (hit(bus_addr, OFF_DHI))  bus_rdata = dog_live[15:8];
   end
endmodule

// File: rtl/wdk_checker.sv
module wdk_checker
   import wdk_pkg::*;
#(
   parameter int ADDR_W = 4,
   parameter int CNT_W  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [7:0]        bus_wdata,
   input logic [5:0]        cfg_q,
   input logic [1:0]        psc_q,
   input logic              stop_q,
   input logic              mode_q,
   input logic [CNT_W-1:0]  dog_cnt,
   input logic              warn_irq,
   input logic              wdog_rst_req
);
   logic key_hit, arm_hit, stat_clr;
   assign key_hit  = bus_wr && bus_addr == OFF_KEY[ADDR_W-1:0] && bus_wdata == KICK_KEY
                     && cfg_q[CFG_KEY_EN];
   assign arm_hit  = bus_wr && bus_addr == OFF_CFG[ADDR_W-1:0] && !cfg_q[CFG_CLOCK]
                     && bus_wdata[CFG_DLOCK] && !cfg_q[CFG_DLOCK];
   assign stat_clr = bus_wr && bus_addr == OFF_CTRL[ADDR_W-1:0] && bus_wdata[CTRL_STAT];

   AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      wdog_rst_req |=> !wdog_rst_req); // R5
   AST_RST_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      wdog_rst_req |-> dog_cnt == '0); // R5
   AST_ZERO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (dog_cnt == '0 && !key_hit && !arm_hit) |=> dog_cnt == '0); // R5
   AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_q[CFG_DLOCK] && stop_q && mode_q && !key_hit) |=> $stable(dog_cnt)); // R9
   AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_q[CFG_CLOCK] |=> $stable(cfg_q)); // R8
   AST_PSC_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_q[CFG_PLOCK] |=> $stable(psc_q)); // R7
   AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (warn_irq && !stat_clr) |=> warn_irq); // R11
endmodule

bind wdk_top wdk_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .bus_wr       (bus_wr),
   .bus_addr     (bus_addr),
   .bus_wdata    (bus_wdata),
   .cfg_q        (cfg_q),
   .psc_q        (psc_q),
   .stop_q       (stop_q),
   .mode_q       (mode_q),
   .dog_cnt      (dog_cnt),
   .warn_irq     (warn_irq),
   .wdog_rst_req (wdog_rst_req)
);

// File: tb/wdk_top_tb.sv
module wdk_top_tb;
   localparam int CLK_PERIOD = 10;
   localparam int ADDR_W = 4;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              ref_tick = 1'b1;
   logic              bus_wr = 1'b0;
   logic [ADDR_W-1:0] bus_addr = '0;
   logic [7:0]        bus_wdata = '0;
   logic [7:0]        bus_rdata;
   logic              warn_irq, wdog_rst_req;

   int checks = 0;
   int errors = 0;
   int pulses = 0;

   wdk_top #(.ADDR_W(ADDR_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .warn_irq(warn_irq), .wdog_rst_req(wdog_rst_req)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(negedge clk) if (rst_n && wdog_rst_req) pulses++;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      pulses = 0;
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      bus_addr = a[ADDR_W-1:0];
      bus_wdata = d;
      bus_wr = 1'b1;
      @(posedge clk);
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output int d);
      bus_addr = a[ADDR_W-1:0];
      #1;
      d = int'(bus_rdata);
   endtask

   task automatic rd_dog(output int v);
      int h, l;
      rd(8'h09, h);
      rd(8'h06, l);
      v = h * 256 + l;
   endtask

   task automatic rd_warn(output int v);
      int h, l;
      rd(8'h03, h);
      rd(8'h04, l);
      v = h * 256 + l;
   endtask

   task automatic waitc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic t_reset();
      int v;
      do_reset();
      foreach (v_addr_list[i]) begin
         rd(v_addr_list[i], v);
         chk(v == 0, "R1 reg reset", v, 0);
      end
      chk(warn_irq == 0, "R1 irq reset", warn_irq, 0);
      chk(wdog_rst_req == 0, "R1 rst_req reset", wdog_rst_req, 0);
   endtask

   logic [7:0] v_addr_list [8] = '{8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07, 8'h09};

   task automatic t_arm_expire_key_stop();
      int v, v0;
      do_reset();
      wr(8'h06, 8'd8);
      wr(8'h38, 8'h00); // unmapped, harmless
      wr(8'h01, 8'h38);
      rd_dog(v);  chk(v == 8, "R4 armed load", v, 8);
      waitc(3);
      rd_dog(v);  chk(v == 5, "R4 countdown", v, 5);
      chk(pulses == 0, "R5 no early pulse", pulses, 0);
      waitc(10);
      rd_dog(v);  chk(v == 0, "R5 holds at zero", v, 0);
      chk(pulses == 1, "R5 one pulse", pulses, 1);
      waitc(5);
      chk(pulses == 1, "R5 single pulse", pulses, 1);
      wr(8'h07, 8'h5C);
      rd_dog(v);  chk(v == 8, "R6 key restart", v, 8);
      waitc(2);
      rd_dog(v0);
      wr(8'h07, 8'h12);
      rd_dog(v);  chk(v == v0 - 1, "R6 wrong key ignored", v, v0 - 1);
      wr(8'h01, 8'h18);
      rd_dog(v0);
      wr(8'h07, 8'h5C);
      rd_dog(v);  chk(v == v0 - 1, "R6 key disabled", v, v0 - 1);
      wr(8'h01, 8'h38);
      wr(8'h06, 8'h03);
      wr(8'h07, 8'h5C);
      rd_dog(v);  chk(v == 8, "R7 dog count locked", v, 8);
      wr(8'h05, 8'h20);
      rd_dog(v0);
      waitc(2);
      rd_dog(v);  chk(v == v0 - 2, "R9 stop without mode", v, v0 - 2);
      wr(8'h07, 8'h5C);
      wr(8'h05, 8'h30);
      rd_dog(v0);
      waitc(4);
      rd_dog(v);  chk(v == v0 && v0 == 7, "R9 stopped", v, 7);
      wr(8'h05, 8'h00);
      wr(8'h01, 8'h30);
      rd_dog(v0);
      waitc(4);
      rd_dog(v);  chk(v == v0, "R4 disarmed holds", v, v0);
      chk(pulses == 1, "R5 no extra pulse", pulses, 1);
   endtask

   task automatic t_locks();
      int v;
      do_reset();
      wr(8'h01, 8'h06);
      wr(8'h02, 8'h02);
      rd(8'h02, v); chk(v == 0, "R7 prescaler locked", v, 0);
      wr(8'h04, 8'h07);
      wr(8'h05, 8'h01);
      rd_warn(v);   chk(v == 0, "R7 warn count locked", v, 0);
      wr(8'h01, 8'h00);
      wr(8'h02, 8'h02);
      rd(8'h02, v); chk(v == 2, "R7 prescaler unlocked", v, 2);
      wr(8'h01, 8'h01);
      wr(8'h01, 8'h38);
      rd(8'h01, v); chk(v == 1, "R8 config locked", v, 1);
   endtask

   task automatic t_prescale();
      int c0, c1;
      do_reset();
      wr(8'h09, 8'h03);
      wr(8'h06, 8'hE8);
      wr(8'h02, 8'h01);
      wr(8'h01, 8'h38);
      waitc(1);
      rd_dog(c0); waitc(64); rd_dog(c1);
      chk(c0 - c1 == 2, "R2 divide by 32", c0 - c1, 2);
      wr(8'h01, 8'h20);
      wr(8'h01, 8'h28);
      rd_dog(c0); chk(c0 == 1000, "R4 rearm load", c0, 1000);
      waitc(10); rd_dog(c1);
      chk(c0 - c1 == 10, "R3 raw source", c0 - c1, 10);
      wr(8'h01, 8'h20);
      wr(8'h02, 8'h02);
      wr(8'h01, 8'h38);
      rd_dog(c0); waitc(2048); rd_dog(c1);
      chk(c0 - c1 == 2, "R2 divide by 1024", c0 - c1, 2);
   endtask

   task automatic t_warning();
      int v;
      do_reset();
      wr(8'h04, 8'd5);
      wr(8'h09, 8'h10);
      wr(8'h01, 8'h38);
      rd_warn(v); chk(v == 5, "R10 warn load", v, 5);
      waitc(3);
      rd_warn(v); chk(v == 2, "R10 warn countdown", v, 2);
      chk(warn_irq == 0, "R10 no early irq", warn_irq, 0);
      waitc(3);
      rd_warn(v); chk(v == 4, "R10 warn reload", v, 4);
      chk(warn_irq == 1, "R10 irq raised", warn_irq, 1);
      waitc(20);
      chk(warn_irq == 1, "R11 irq sticky", warn_irq, 1);
      wr(8'h05, 8'h00);
      chk(warn_irq == 1, "R11 write0 keeps", warn_irq, 1);
      wr(8'h01, 8'h30);
      wr(8'h05, 8'h02);
      chk(warn_irq == 0, "R11 cleared", warn_irq, 0);
      wr(8'h05, 8'h01);
      rd_warn(v); chk(v == 5, "R12 warn reset reload", v, 5);
      rd(8'h05, v); chk(v == 0, "R12 bit0 reads zero", v, 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      t_reset();
      t_arm_expire_key_stop();
      t_locks();
      t_prescale();
      t_warning();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule